// File: doc/BRIEF.md
# Inter-Processor Mailbox with Ownership Handshake

A register-mapped mailbox that lets one processor hand a short block of data words to another. It has several channels, and each channel works on its own. Processors are named by one-hot identity codes. A sender takes a free channel by writing its identity to the channel's owner register. It then reads that register back: if the read value is its own identity, it holds the channel. The sender picks the recipients, fills in the data words and writes its identity to the send register. The chosen recipients then see an interrupt.

The channel must be acknowledged before the exchange is complete. In automatic mode the acknowledge comes one cycle after the send. In manual mode it comes when a recipient writes its own identity to the clear register. The acknowledge raises an interrupt back to the sender, which clears it and then frees the channel by writing its identity to the owner register a second time.

Each channel has an interrupt mask that applies to every processor. For each processor there is a status word with one bit per channel that shows its pending interrupts. A key register guards every channel register: writes only take effect after the key has been written.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every channel is free: its mode word reads 0x10, its owner reads 0, its mask reads all ones (0x3F with six identities), no interrupt output is high, and the key register at 0xA00 reads 1 (locked).
- R2: Writing 0x1ACCE551 to 0xA00 unlocks the block, so that 0xA00 reads 0. Writing any other value there locks it again. While the block is locked, writes to channel registers have no effect.
- R3: Channel c occupies the 64-byte window at c*0x40, with the owner register at offset 0x00. Writing a one-hot identity to a free channel's owner register claims the channel: the register reads that identity back and the mode word reads 0x2X. A write to the owner register from any other identity while the channel is held is ignored, so a losing contender reads back the winner's identity.
- R4: When the holder writes its own identity to the owner register again, the channel returns to free (mode 0x10, owner 0, pending interrupts cleared). A write of a different identity does not free it.
- R5: Destinations are set with a write to offset 0x04 (the written bits are added) and removed with a write to offset 0x08 (the written bits are cleared). They read back at offset 0x0C. A write of the holder's identity to offset 0x1C while the channel is claimed delivers the message: the mode word shows 0x4X and each destination's pending bit is set. A send write with any other value is ignored.
- R6: The mask at offset 0x14 blocks a pending bit from the interrupt outputs and from the status words, but does not clear it.
- R7: Mode word layout: bits [7:4] hold the state (0x1 free, 0x2 claimed, 0x4 delivered, 0x8 acknowledged) and bit 0 holds the automatic-acknowledge bit. The holder sets that bit by writing 1 to offset 0x10. With the bit set, the channel moves to acknowledged one cycle after delivery and sets the holder's pending bit.
- R8: With the automatic bit clear, a delivered channel moves to acknowledged, and sets the holder's pending bit, when a write to offset 0x18 contains at least one destination bit.
- R9: A write to offset 0x18 clears the written bits from the channel's pending bits.
- R10: The status word for identity bit p sits at 0x800 + 8*p. Its bit c shows channel c's unmasked pending bit p. Interrupt output p is the OR of that word.
- R11: The data words at offsets 0x20, 0x24, ... can be written while the channel is held, and they read back what was written.
- R12: An owner write that is not one-hot, and a mode write to a free channel, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational from bus_addr |
| irq_o | output | NP (6) | Interrupt line for each identity |

## Verification
A channel stuck in the wrong state is visible at the next read of its mode word. The same fault also shows on the interrupt lines no later than the cycle after the send or the clear that should have moved it. A wrong pending or mask bit changes irq_o in the same cycle, and the bench compares irq_o against its reference model on every clock. A missed lock gate, or a write that was supposed to be ignored but took effect, is caught by reading back the affected owner, mode or mask register right after the write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int ADDR_W = 12;
   localparam int DW     = 32;

   typedef enum logic [3:0] {
      ST_FREE  = 4'h1,
      ST_HELD  = 4'h2,
      ST_SENT  = 4'h4,
      ST_ACKED = 4'h8
   } chan_state_e;

   localparam logic [5:0] OFS_OWNER = 6'h00;
   localparam logic [5:0] OFS_DSET  = 6'h04;
   localparam logic [5:0] OFS_DCLR  = 6'h08;
   localparam logic [5:0] OFS_DSTAT = 6'h0C;
   localparam logic [5:0] OFS_MODE  = 6'h10;
   localparam logic [5:0] OFS_MASK  = 6'h14;
   localparam logic [5:0] OFS_ICLR  = 6'h18;
   localparam logic [5:0] OFS_SEND  = 6'h1C;

   localparam logic [ADDR_W-1:0] KEY_ADDR = 12'hA00;
endpackage

// File: rtl/mbx_channel.sv
module mbx_channel
   import mbx_pkg::*;
#(
   parameter int NP       = 6,
   parameter int NUM_DATA = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [5:0]    off,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [NP-1:0] vis,
   output logic [3:0]    st_code,
   output logic [NP-1:0] owner_o,
   output logic          auto_o,
   output logic [NP-1:0] mask_o
);
   localparam int IDX_W = 3;

   chan_state_e   st_q, st_n;
   logic [NP-1:0] own_q, own_n, mask_q, mask_n, dest_q, dest_n, pend_q, pend_n;
   logic          auto_q, auto_n;
   logic [DW-1:0] data_q [NUM_DATA];
   logic [DW-1:0] data_n [NUM_DATA];

   logic [NP-1:0]    wid;
   logic             hi_zero, id_ok, is_holder, busy, in_data;
   logic [IDX_W-1:0] didx;

   assign wid       = wdata[NP-1:0];
   assign hi_zero   = (wdata[DW-1:NP] == '0);
   assign id_ok     = hi_zero && $onehot(wid);
   assign is_holder = hi_zero && (wid == own_q);
   assign busy      = (st_q != ST_FREE);
   assign in_data   = off[5] && (off[1:0] == 2'b00);
   assign didx      = off[4:2];

   always_comb begin
      st_n   = st_q;
      own_n  = own_q;
      auto_n = auto_q;
      mask_n = mask_q;
      dest_n = dest_q;
      pend_n = pend_q;
      for (int d = 0; d < NUM_DATA; d++) data_n[d] = data_q[d];
      if (st_q == ST_SENT && auto_q) begin
         st_n   = ST_ACKED;
         pend_n = pend_n | own_q;
      end
      if (wr_en) begin
         case (off)
            OFS_OWNER: begin
               if (!busy) begin
                  if (id_ok) begin
                     st_n  = ST_HELD;
                     own_n = wid;
                  end
               end else if (is_holder) begin
                  st_n   = ST_FREE;
                  own_n  = '0;
                  auto_n = 1'b0;
                  dest_n = '0;
                  pend_n = '0;
               end
            end
            OFS_DSET: if (busy) dest_n = dest_q | wid;
            OFS_DCLR: if (busy) dest_n = dest_q & ~wid;
            OFS_MODE: if (busy) auto_n = wdata[0];
            OFS_MASK: mask_n = wid;
            OFS_ICLR: begin
               pend_n = pend_n & ~wid;
               if (st_q == ST_SENT && !auto_q && ((wid & dest_q) != '0)) begin
                  st_n   = ST_ACKED;
                  pend_n = pend_n | own_q;
               end
            end
            OFS_SEND: begin
               if (st_q == ST_HELD && is_holder) begin
                  st_n   = ST_SENT;
                  pend_n = pend_q | dest_q;
               end
            end
            default: begin
               if (in_data && busy) begin
                  for (int d = 0; d < NUM_DATA; d++)
                     if (didx == IDX_W'(d)) data_n[d] = wdata;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_FREE;
         own_q  <= '0;
         auto_q <= 1'b0;
         mask_q <= '1;
         dest_q <= '0;
         pend_q <= '0;
         for (int d = 0; d < NUM_DATA; d++) data_q[d] <= '0;
      end else begin
         st_q   <= st_n;
         own_q  <= own_n;
         auto_q <= auto_n;
         mask_q <= mask_n;
         dest_q <= dest_n;
         pend_q <= pend_n;
         for (int d = 0; d < NUM_DATA; d++) data_q[d] <= data_n[d];
      end
   end

   always_comb begin
      rdata = '0;
      case (off)
         OFS_OWNER: rdata[NP-1:0] = own_q;
         OFS_DSTAT: rdata[NP-1:0] = dest_q;
         OFS_MODE:  rdata[7:0]    = {st_q, 3'b000, auto_q};
         OFS_MASK:  rdata[NP-1:0] = mask_q;
         default: begin
            if (in_data) begin
               for (int d = 0; d < NUM_DATA; d++)
                  if (didx == IDX_W'(d)) rdata = data_q[d];
            end
         end
      endcase
   end

   assign vis     = pend_q & ~mask_q;
   assign st_code = st_q;
   assign owner_o = own_q;
   assign auto_o  = auto_q;
   assign mask_o  = mask_q;
endmodule

// File: rtl/mbx_irq_route.sv
module mbx_irq_route #(
   parameter int NUM_CH = 4,
   parameter int NP     = 6
) (
   input  logic [NP-1:0]     vis  [NUM_CH],
   output logic [NP-1:0]     irq,
   output logic [NUM_CH-1:0] stat [NP]
);
   for (genvar p = 0; p < NP; p++) begin : g_proc
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign stat[p][c] = vis[c][p];
      end
      assign irq[p] = |stat[p];
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import mbx_pkg::*;
#(
   parameter int          NUM_CH   = 4,
   parameter int          NUM_DATA = 2,
   parameter int          NP       = 6,
   parameter logic [31:0] LOCK_KEY = 32'h1ACC_E551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic [NP-1:0]     irq_o
);
   localparam int SEL_W = 5;

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("ipc_mailbox: NUM_CH must be 1..32");
   end
   if (NUM_DATA < 1 || NUM_DATA > 8) begin : g_bad_data
      $error("ipc_mailbox: NUM_DATA must be 1..8");
   end
   if (NP < 4 || NP > 31) begin : g_bad_np
      $error("ipc_mailbox: NP must be 4..31");
   end

   logic             locked_q;
   logic             in_ch, key_hit, stat_hit;
   logic [SEL_W-1:0] ch_sel, p_sel;

   logic [DW-1:0]     ch_rdata [NUM_CH];
   logic [NP-1:0]     ch_vis   [NUM_CH];
   logic [3:0]        ch_st    [NUM_CH];
   logic [NP-1:0]     ch_own   [NUM_CH];
   logic              ch_auto  [NUM_CH];
   logic [NP-1:0]     ch_mask  [NUM_CH];
   logic [NUM_CH-1:0] p_stat   [NP];

   assign in_ch    = (bus_addr[11] == 1'b0);
   assign ch_sel   = bus_addr[10:6];
   assign key_hit  = (bus_addr == KEY_ADDR);
   assign stat_hit = (bus_addr[11:8] == 4'h8) && (bus_addr[2:0] == 3'b000);
   assign p_sel    = bus_addr[7:3];

   always_ff @(posedge clk) begin
      if (!rst_n)                 locked_q <= 1'b1;
      else if (bus_wr && key_hit) locked_q <= (bus_wdata != LOCK_KEY);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic wr_c;
      assign wr_c = bus_wr && !locked_q && in_ch && (ch_sel == SEL_W'(c));
      mbx_channel #(.NP(NP), .NUM_DATA(NUM_DATA)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_c),
         .off     (bus_addr[5:0]),
         .wdata   (bus_wdata),
         .rdata   (ch_rdata[c]),
         .vis     (ch_vis[c]),
         .st_code (ch_st[c]),
         .owner_o (ch_own[c]),
         .auto_o  (ch_auto[c]),
         .mask_o  (ch_mask[c])
      );
   end

   mbx_irq_route #(.NUM_CH(NUM_CH), .NP(NP)) u_route (
      .vis  (ch_vis),
      .irq  (irq_o),
      .stat (p_stat)
   );

   always_comb begin
      bus_rdata = '0;
      if (key_hit) begin
         bus_rdata[0] = locked_q;
      end else if (in_ch) begin
         for (int c = 0; c < NUM_CH; c++)
            if (ch_sel == SEL_W'(c)) bus_rdata = ch_rdata[c];
      end else if (stat_hit) begin
         for (int p = 0; p < NP; p++)
            if (p_sel == SEL_W'(p)) bus_rdata[NUM_CH-1:0] = p_stat[p];
      end
   end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
   parameter int NUM_CH = 4,
   parameter int NP     = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [5:0]    win,
   input logic          locked_q,
   input logic [NP-1:0] irq_o,
   input logic [3:0]    ch_st   [NUM_CH],
   input logic [NP-1:0] ch_own  [NUM_CH],
   input logic          ch_auto [NUM_CH],
   input logic [NP-1:0] ch_mask [NUM_CH]
);
   logic [NP-1:0] all_masked;
   always_comb begin
      all_masked = '1;
      for (int c = 0; c < NUM_CH; c++) all_masked = all_masked & ch_mask[c];
   end

   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o & all_masked) == '0); // R6

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (locked_q && bus_wr && win == {1'b0, 5'(c)}) |=> ($stable(ch_own[c]) && $stable(ch_mask[c]))); // R2
      AST_FREE_NO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_st[c] == 4'h1) |-> (ch_own[c] == '0)); // R4
      AST_HELD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_st[c] != 4'h1) |-> $onehot(ch_own[c])); // R3
      AST_AUTO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_st[c] == 4'h4 && ch_auto[c] && !bus_wr) |=> (ch_st[c] == 4'h8)); // R7
      AST_SEND_FROM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_st[c] == 4'h4) |-> $past(ch_st[c] == 4'h2)); // R5
   end
endmodule

bind ipc_mailbox mbx_checker #(.NUM_CH(NUM_CH), .NP(NP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .win      (bus_addr[11:6]),
   .locked_q (locked_q),
   .irq_o    (irq_o),
   .ch_st    (ch_st),
   .ch_own   (ch_own),
   .ch_auto  (ch_auto),
   .ch_mask  (ch_mask)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
   localparam int NUM_CH = 4, NUM_DATA = 2, NP = 6;
   localparam logic [31:0] KEY = 32'h1ACC_E551;

   logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [NP-1:0] irq_o;
   int n_tests = 0, n_fail = 0;

   always #2 clk = ~clk;

   ipc_mailbox u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

   // behavioural reference model
   logic          m_locked;
   logic [3:0]    m_st   [NUM_CH];
   logic [NP-1:0] m_own  [NUM_CH];
   logic          m_auto [NUM_CH];
   logic [NP-1:0] m_mask [NUM_CH];
   logic [NP-1:0] m_dest [NUM_CH];
   logic [NP-1:0] m_pend [NUM_CH];
   logic [31:0]   m_data [NUM_CH][NUM_DATA];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_locked = 1'b1;
         for (int c = 0; c < NUM_CH; c++) begin
            m_st[c] = 4'h1; m_own[c] = '0; m_auto[c] = 1'b0; m_mask[c] = '1;
            m_dest[c] = '0; m_pend[c] = '0;
            for (int d = 0; d < NUM_DATA; d++) m_data[c][d] = '0;
         end
      end else begin
         logic [3:0] old_st [NUM_CH];
         logic       old_auto [NUM_CH];
         for (int c = 0; c < NUM_CH; c++) begin
            old_st[c] = m_st[c];
            old_auto[c] = m_auto[c];
            if (m_st[c] == 4'h4 && m_auto[c]) begin
               m_st[c] = 4'h8; m_pend[c] |= m_own[c];
            end
         end
         if (bus_wr) begin
            if (bus_addr == 12'hA00) m_locked = (bus_wdata != KEY);
            else if (!m_locked && !bus_addr[11] && int'(bus_addr[10:6]) < NUM_CH) begin
               int c;
               logic [NP-1:0] w;
               logic ok_hi;
               c = int'(bus_addr[10:6]);
               w = bus_wdata[NP-1:0];
               ok_hi = ((bus_wdata >> NP) == 0);
               case (bus_addr[5:0])
                  6'h00: if (old_st[c] == 4'h1) begin
                            if (ok_hi && $onehot(w)) begin m_st[c] = 4'h2; m_own[c] = w; end
                         end else if (ok_hi && w == m_own[c]) begin
                            m_st[c] = 4'h1; m_own[c] = '0; m_auto[c] = 1'b0;
                            m_dest[c] = '0; m_pend[c] = '0;
                         end
                  6'h04: if (old_st[c] != 4'h1) m_dest[c] |= w;
                  6'h08: if (old_st[c] != 4'h1) m_dest[c] &= ~w;
                  6'h10: if (old_st[c] != 4'h1) m_auto[c] = bus_wdata[0];
                  6'h14: m_mask[c] = w;
                  6'h18: begin
                     m_pend[c] &= ~w;
                     if (old_st[c] == 4'h4 && !old_auto[c] && (w & m_dest[c]) != 0) begin
                        m_st[c] = 4'h8; m_pend[c] |= m_own[c];
                     end
                  end
                  6'h1C: if (old_st[c] == 4'h2 && ok_hi && w == m_own[c]) begin
                     m_st[c] = 4'h4; m_pend[c] |= m_dest[c];
                  end
                  default: if (bus_addr[5] && bus_addr[1:0] == 0 && int'(bus_addr[4:2]) < NUM_DATA
                               && old_st[c] != 4'h1)
                     m_data[c][bus_addr[4:2]] = bus_wdata;
               endcase
            end
         end
      end
   end

   function automatic logic [31:0] mread(logic [11:0] a);
      logic [31:0] r;
      r = '0;
      if (a == 12'hA00) r[0] = m_locked;
      else if (!a[11]) begin
         int c;
         c = int'(a[10:6]);
         if (c < NUM_CH) case (a[5:0])
            6'h00: r[NP-1:0] = m_own[c];
            6'h0C: r[NP-1:0] = m_dest[c];
            6'h10: r[7:0] = {m_st[c], 3'b000, m_auto[c]};
            6'h14: r[NP-1:0] = m_mask[c];
            default: if (a[5] && a[1:0] == 0 && int'(a[4:2]) < NUM_DATA) r = m_data[c][a[4:2]];
         endcase
      end else if (a[11:8] == 4'h8 && a[2:0] == 0) begin
         int p;
         p = int'(a[7:3]);
         if (p < NP) for (int c = 0; c < NUM_CH; c++) r[c] = m_pend[c][p] & ~m_mask[c][p];
      end
      return r;
   endfunction

   function automatic logic [NP-1:0] mirq();
      logic [NP-1:0] r;
      r = '0;
      for (int c = 0; c < NUM_CH; c++) r |= m_pend[c] & ~m_mask[c];
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   // irq compared with the model on every clock
   always @(negedge clk) if (rst_n) chk("R10 irq_o vs model", 32'(irq_o), 32'(mirq()));

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
      chk({req, " model"}, bus_rdata, mread(a));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd("R1 mode ch0", 12'h010, 32'h10);
      rd("R1 owner ch0", 12'h000, 32'h0);
      rd("R1 mask ch3", 12'h0D4, 32'h3F);
      rd("R1 locked", 12'hA00, 32'h1);
      chk("R1 irq", 32'(irq_o), 32'h0);
      // R2 locked writes ignored
      wr(12'h000, 32'h1);
      rd("R2 locked owner write", 12'h000, 32'h0);
      wr(12'hA00, KEY);
      rd("R2 unlocked", 12'hA00, 32'h0);
      // R3 claim and contention
      wr(12'h040, 32'h1);
      rd("R3 claim readback", 12'h040, 32'h1);
      rd("R3 mode held", 12'h050, 32'h20);
      wr(12'h040, 32'h2);
      rd("R3 loser reads winner", 12'h040, 32'h1);
      // R12 invalid id and mode write on free channel
      wr(12'h080, 32'h3);
      rd("R12 non-onehot claim", 12'h080, 32'h0);
      wr(12'h090, 32'h1);
      rd("R12 mode on free", 12'h090, 32'h10);
      // R11 data and destinations
      wr(12'h050, 32'h1);
      rd("R7 auto bit", 12'h050, 32'h21);
      wr(12'h054, 32'h36);
      wr(12'h044, 32'h0C);
      wr(12'h048, 32'h04);
      rd("R5 dest set/clear", 12'h04C, 32'h08);
      wr(12'h060, 32'hCAFE_0001);
      wr(12'h064, 32'h1234_5678);
      rd("R11 data0", 12'h060, 32'hCAFE_0001);
      rd("R11 data1", 12'h064, 32'h1234_5678);
      // R5 send with wrong id, then correct id
      wr(12'h05C, 32'h2);
      rd("R5 wrong send ignored", 12'h050, 32'h21);
      wr(12'h05C, 32'h1);
      rd("R5 delivered", 12'h050, 32'h41);
      chk("R5 dest irq", 32'(irq_o), 32'h08);
      @(negedge clk);
      rd("R7 auto ack", 12'h050, 32'h81);
      chk("R7 sender irq", 32'(irq_o), 32'h09);
      rd("R10 status p3", 12'h818, 32'h2);
      rd("R10 status p0", 12'h800, 32'h2);
      // R9 clears, R4 release
      wr(12'h058, 32'h08);
      wr(12'h058, 32'h01);
      chk("R9 irq cleared", 32'(irq_o), 32'h0);
      wr(12'h040, 32'h1);
      rd("R4 released mode", 12'h050, 32'h10);
      rd("R4 released owner", 12'h040, 32'h0);
      // R8 manual acknowledge on ch0, R6 masking
      wr(12'h000, 32'h2);
      wr(12'h014, 32'h0);
      wr(12'h004, 32'h4);
      wr(12'h01C, 32'h2);
      rd("R5 manual delivered", 12'h010, 32'h40);
      chk("R5 manual dest irq", 32'(irq_o), 32'h04);
      wr(12'h014, 32'h4);
      chk("R6 masked irq", 32'(irq_o), 32'h0);
      rd("R6 masked status", 12'h810, 32'h0);
      wr(12'h014, 32'h0);
      chk("R6 unmasked pending kept", 32'(irq_o), 32'h04);
      wr(12'h018, 32'h4);
      rd("R8 manual ack", 12'h010, 32'h80);
      chk("R8 sender irq", 32'(irq_o), 32'h02);
      wr(12'h018, 32'h2);
      chk("R9 sender cleared", 32'(irq_o), 32'h0);
      wr(12'h000, 32'h1);
      rd("R4 non-owner release ignored", 12'h000, 32'h2);
      wr(12'h000, 32'h2);
      rd("R4 owner release", 12'h010, 32'h10);
      // R2 relock
      wr(12'hA00, 32'h0);
      rd("R2 relocked", 12'hA00, 32'h1);
      wr(12'h0C0, 32'h1);
      rd("R2 write while relocked", 12'h0C0, 32'h0);
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule